// File: doc/BRIEF.md
# Byte-Lane Bus Demultiplexer

This block joins a host that moves 16-bit words over an 8-bit byte bus to a peripheral with a native 16-bit data bus. The host splits every word access into two byte cycles. A lane-select address bit tells the two cycles apart. The low-order byte always travels first with the lane bit high. The high-order byte follows with the lane bit low. The block steers each byte onto the correct half of the 16-bit bus. On writes it keeps the early low byte in a holding register, so the peripheral gets a single complete word when the second byte arrives. On reads it returns the low half and then the high half of the peripheral word in turn.

The two buses number their bits in opposite directions. On the byte bus, bit 0 is the most significant bit. On the word bus, bit 15 is the most significant bit. Every lane connection therefore reverses the index. The buses are split into separate in, out and enable vectors, so that the pad ring can build the tristate drivers. The host never writes a lone byte: each write pair is preceded by a read pair to the same two addresses. Address decoding stays outside the block and arrives as an active-low card select.

Top module: `bytelane_demux`

## Requirements
- R1: After reset the holding register is zero, so an even-byte write with no earlier odd-byte write presents 0 on the low half of the word bus.
- R2: On a clock edge where the card is selected, the lane bit is 1, the read strobe is 0 and the active-low write strobe is 0, the holding register takes the byte bus value.
- R3: In an even-byte write cycle (selected, lane bit 0, read strobe 0), `word_oe` is 1. The word bus high half carries the live byte bus and the low half carries the holding register.
- R4: In an odd-byte read (selected, lane bit 1, read strobe 1), `byte_oe` is 1 and the byte bus carries the word bus low half (word bits 7..0).
- R5: In an even-byte read (selected, lane bit 0, read strobe 1), `byte_oe` is 1 and the byte bus carries the word bus high half (word bits 15..8).
- R6: Lane indices are reversed. Byte bus bit k maps to word bit 15-k in the high lane and to word bit 7-k in the low lane. For example, byte value 8'h01 is seen as 8'h80 in either half.
- R7: With card select high, `byte_oe` and `word_oe` are 0, both data outputs are 0, `per_wr_n` is 1, and the holding register does not change.
- R8: `per_wr_n` is 0 only in an even-byte write cycle with the write strobe at 0. It stays 1 during odd-byte writes and during all reads.
- R9: Read cycles, and odd-byte cycles without a write strobe, leave the holding register unchanged.
- R10: `byte_oe` and `word_oe` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| card_sel_n | input | 1 | Active-low card select from the external decoder |
| lane_odd | input | 1 | Lane bit: 1 for the low-order (odd) byte, 0 for the high-order (even) byte |
| rd_dir | input | 1 | Read strobe: 1 for read, 0 for write |
| wr_n | input | 1 | Active-low write strobe from the host |
| byte_in | input | BW | Byte bus value seen from the host, bit 0 most significant |
| byte_out | output | BW | Byte bus value driven back to the host |
| byte_oe | output | 1 | Tristate enable for `byte_out` |
| word_in | input | 2*BW | Word bus value from the peripheral, top bit most significant |
| word_out | output | 2*BW | Word bus value driven to the peripheral |
| word_oe | output | 1 | Tristate enable for `word_out` |
| per_wr_n | output | 1 | Active-low word write strobe to the peripheral |

## Verification
Two functions meet at a single clock edge: the capture of the odd byte and the use of that byte in the next even-byte write cycle. The bench runs an odd write followed at once by an even write, with no idle cycle between them. It then requires the low half of the word bus to show the byte just captured, not the value held before. The same is true in the random traffic, where the bench's own model of the holding register is updated only at the capturing edge. The bench also covers a read that follows a write directly. There the byte-bus enable must switch on in the very cycle the word-bus enable switches off.

// File: rtl/demux_pkg.sv
package demux_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE    = 3'd0,
    CYC_ODD_RD  = 3'd1,
    CYC_ODD_WR  = 3'd2,
    CYC_EVEN_RD = 3'd3,
    CYC_EVEN_WR = 3'd4
  } cyc_t;
endpackage

// File: rtl/lane_flip.sv
module lane_flip #(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dout[i] = din[W-1-i];
  end
endmodule

// File: rtl/cycle_decode.sv
module cycle_decode
  import demux_pkg::*;
(
  input  logic card_sel_n,
  input  logic lane_odd,
  input  logic rd_dir,
  output cyc_t cyc
);
  always_comb begin
    if (card_sel_n)    cyc = CYC_IDLE;
    else if (lane_odd) cyc = rd_dir ? CYC_ODD_RD : CYC_ODD_WR;
    else               cyc = rd_dir ? CYC_EVEN_RD : CYC_EVEN_WR;
  end
endmodule

// File: rtl/odd_hold_reg.sv
module odd_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (cap_en) q_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/lane_steer.sv
module lane_steer
  import demux_pkg::*;
#(
  parameter int BW = 8,
  localparam int WW = 2 * BW
) (
  input  cyc_t          cyc,
  input  logic          wr_n,
  input  logic [BW-1:0] live_w,
  input  logic [BW-1:0] hold_w,
  input  logic [BW-1:0] lo_b,
  input  logic [BW-1:0] hi_b,
  output logic [BW-1:0] byte_out,
  output logic          byte_oe,
  output logic [WW-1:0] word_out,
  output logic          word_oe,
  output logic          per_wr_n
);
  always_comb begin
    byte_out = '0;
    byte_oe  = 1'b0;
    word_out = '0;
    word_oe  = 1'b0;
    per_wr_n = 1'b1;
    unique case (cyc)
      CYC_ODD_RD: begin
        byte_oe  = 1'b1;
        byte_out = lo_b;
      end
      CYC_EVEN_RD: begin
        byte_oe  = 1'b1;
        byte_out = hi_b;
      end
      CYC_EVEN_WR: begin
        word_oe  = 1'b1;
        word_out = {live_w, hold_w};
        per_wr_n = wr_n;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bytelane_demux.sv
module bytelane_demux
  import demux_pkg::*;
#(
  parameter int BW = 8,
  localparam int WW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          card_sel_n,
  input  logic          lane_odd,
  input  logic          rd_dir,
  input  logic          wr_n,
  input  logic [BW-1:0] byte_in,
  output logic [BW-1:0] byte_out,
  output logic          byte_oe,
  input  logic [WW-1:0] word_in,
  output logic [WW-1:0] word_out,
  output logic          word_oe,
  output logic          per_wr_n
);
  logic [1:0]    rst_sync;
  logic          rst_ok_n;
  cyc_t          cyc;
  logic          cap_en;
  logic [BW-1:0] live_w;
  logic [BW-1:0] hold_q;
  logic [BW-1:0] half_b [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok_n = rst_sync[1];

  cycle_decode u_dec (
    .card_sel_n (card_sel_n),
    .lane_odd   (lane_odd),
    .rd_dir     (rd_dir),
    .cyc        (cyc)
  );

  assign cap_en = (cyc == CYC_ODD_WR) && !wr_n;

  lane_flip #(.W(BW)) u_flip_in (
    .din  (byte_in),
    .dout (live_w)
  );

  for (genvar h = 0; h < 2; h++) begin : g_half
    lane_flip #(.W(BW)) u_flip_half (
      .din  (word_in[h*BW +: BW]),
      .dout (half_b[h])
    );
  end

  odd_hold_reg #(.W(BW)) u_hold (
    .clk    (clk),
    .rst_n  (rst_ok_n),
    .cap_en (cap_en),
    .din    (live_w),
    .q      (hold_q)
  );

  lane_steer #(.BW(BW)) u_steer (
    .cyc      (cyc),
    .wr_n     (wr_n),
    .live_w   (live_w),
    .hold_w   (hold_q),
    .lo_b     (half_b[0]),
    .hi_b     (half_b[1]),
    .byte_out (byte_out),
    .byte_oe  (byte_oe),
    .word_out (word_out),
    .word_oe  (word_oe),
    .per_wr_n (per_wr_n)
  );
endmodule

// File: rtl/bytelane_demux_chk.sv
module bytelane_demux_chk #(
  parameter int BW = 8,
  localparam int WW = 2 * BW
) (
  input logic          clk,
  input logic          rst_ok_n,
  input logic          card_sel_n,
  input logic          lane_odd,
  input logic          rd_dir,
  input logic          wr_n,
  input logic [BW-1:0] byte_in,
  input logic [BW-1:0] byte_out,
  input logic          byte_oe,
  input logic [WW-1:0] word_in,
  input logic [WW-1:0] word_out,
  input logic          word_oe,
  input logic          per_wr_n,
  input logic [BW-1:0] hold_q
);
  function automatic logic [BW-1:0] rev(input logic [BW-1:0] v);
    logic [BW-1:0] r;
    for (int i = 0; i < BW; i++) r[i] = v[BW-1-i];
    return r;
  endfunction

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!card_sel_n && lane_odd && !rd_dir && !wr_n) |=> (hold_q == rev($past(byte_in))));

  assert_even_wr_lanes_R3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!card_sel_n && !lane_odd && !rd_dir) |->
      (word_oe && word_out == {rev(byte_in), hold_q}));

  assert_odd_rd_R4: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!card_sel_n && lane_odd && rd_dir) |-> (byte_oe && byte_out == rev(word_in[BW-1:0])));

  assert_even_rd_R5: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!card_sel_n && !lane_odd && rd_dir) |-> (byte_oe && byte_out == rev(word_in[WW-1:BW])));

  assert_quiet_deselect_R7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    card_sel_n |-> (!byte_oe && !word_oe && per_wr_n));

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    card_sel_n |=> $stable(hold_q));

  assert_strobe_window_R8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !per_wr_n |-> (!card_sel_n && !lane_odd && !rd_dir && !wr_n));

  assert_hold_on_read_R9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!card_sel_n && rd_dir) |=> $stable(hold_q));

  assert_no_contention_R10: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !(byte_oe && word_oe));
endmodule

bind bytelane_demux bytelane_demux_chk #(.BW(BW)) u_chk (
  .clk        (clk),
  .rst_ok_n   (rst_ok_n),
  .card_sel_n (card_sel_n),
  .lane_odd   (lane_odd),
  .rd_dir     (rd_dir),
  .wr_n       (wr_n),
  .byte_in    (byte_in),
  .byte_out   (byte_out),
  .byte_oe    (byte_oe),
  .word_in    (word_in),
  .word_out   (word_out),
  .word_oe    (word_oe),
  .per_wr_n   (per_wr_n),
  .hold_q     (hold_q)
);

// File: tb/bytelane_demux_bench.sv
`timescale 1ns/1ps
module bytelane_demux_bench;
  localparam int BW = 8;
  localparam int WW = 16;

  logic          clk;
  logic          rst_n;
  logic          card_sel_n;
  logic          lane_odd;
  logic          rd_dir;
  logic          wr_n;
  logic [BW-1:0] byte_in;
  logic [BW-1:0] byte_out;
  logic          byte_oe;
  logic [WW-1:0] word_in;
  logic [WW-1:0] word_out;
  logic          word_oe;
  logic          per_wr_n;

  int            n_chk;
  int            n_fail;
  logic [BW-1:0] m_hold;
  logic          done;

  bytelane_demux #(.BW(BW)) u_bytelane_demux (
    .clk        (clk),
    .rst_n      (rst_n),
    .card_sel_n (card_sel_n),
    .lane_odd   (lane_odd),
    .rd_dir     (rd_dir),
    .wr_n       (wr_n),
    .byte_in    (byte_in),
    .byte_out   (byte_out),
    .byte_oe    (byte_oe),
    .word_in    (word_in),
    .word_out   (word_out),
    .word_oe    (word_oe),
    .per_wr_n   (per_wr_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] swap8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = v[i];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic s_n, input logic a, input logic r, input logic w_n,
                       input logic [7:0] b, input logic [15:0] wd);
    @(negedge clk);
    card_sel_n = s_n; lane_odd = a; rd_dir = r; wr_n = w_n;
    byte_in = b; word_in = wd;
  endtask

  task automatic check_now();
    logic       sel;
    logic       e_boe;
    logic       e_woe;
    logic [7:0] e_bout;
    logic [15:0] e_wout;
    logic       e_pw;
    string      tag;
    #5;
    sel    = !card_sel_n;
    e_boe  = sel && rd_dir;
    e_woe  = sel && !lane_odd && !rd_dir;
    e_bout = !e_boe ? 8'h00 : (lane_odd ? swap8(word_in[7:0]) : swap8(word_in[15:8]));
    e_wout = e_woe ? {swap8(byte_in), m_hold} : 16'h0000;
    e_pw   = !(e_woe && !wr_n);
    if (!sel)               tag = "R7";
    else if (e_woe)         tag = "R3";
    else if (rd_dir && lane_odd) tag = "R4";
    else if (rd_dir)        tag = "R5";
    else                    tag = "R8";
    chk({tag, " byte_oe"},  {31'd0, byte_oe},  {31'd0, e_boe});
    chk({tag, " byte_out"}, {24'd0, byte_out}, {24'd0, e_bout});
    chk({tag, " word_oe"},  {31'd0, word_oe},  {31'd0, e_woe});
    chk({tag, " word_out"}, {16'd0, word_out}, {16'd0, e_wout});
    chk({tag, " per_wr_n"}, {31'd0, per_wr_n}, {31'd0, e_pw});
    chk("R10 no overlap", {31'd0, byte_oe && word_oe}, 32'd0);
    @(posedge clk);
    if (sel && lane_odd && !rd_dir && !wr_n) m_hold = swap8(byte_in);
  endtask

  task automatic step(input logic s_n, input logic a, input logic r, input logic w_n,
                      input logic [7:0] b, input logic [15:0] wd);
    drive(s_n, a, r, w_n, b, wd);
    check_now();
  endtask

  initial begin
    done = 1'b0;
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    n_chk = 0; n_fail = 0; m_hold = 8'h00;
    rst_n = 1'b0; card_sel_n = 1'b1; lane_odd = 1'b0; rd_dir = 1'b0; wr_n = 1'b1;
    byte_in = 8'h00; word_in = 16'h0000;
    repeat (3) @(posedge clk);
    #3;
    chk("R1 reset byte_oe", {31'd0, byte_oe}, 32'd0);
    chk("R1 reset per_wr_n", {31'd0, per_wr_n}, 32'd1);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: even write right after reset shows zero low half
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h5A, 16'h0000);
    chk("R1 low half after reset", {16'd0, word_out}, {16'd0, swap8(8'h5A), 8'h00});

    // R6: byte bit 0 maps to word bit 15 / bit 7
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h01, 16'h0000);
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h01, 16'h0000);
    chk("R6 reversed lanes", {16'd0, word_out}, 32'h0000_8080);
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 16'h0001);
    chk("R6 read reversal", {24'd0, byte_out}, 32'h0000_0080);

    // R2: back-to-back odd write then even write uses the new byte
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'hC3, 16'h0000);
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 16'h0000);
    chk("R2 fresh odd byte", {24'd0, word_out[7:0]}, {24'd0, swap8(8'hC3)});

    // R7: deselected write strobe does not alter hold
    step(1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 16'h0000);
    // R9: reads and strobe-less odd cycles leave hold
    step(1'b0, 1'b1, 1'b1, 1'b0, 8'hEE, 16'hABCD);
    step(1'b0, 1'b1, 1'b0, 1'b1, 8'hDD, 16'h0000);
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 16'h0000);
    chk("R9 hold retained", {24'd0, word_out[7:0]}, {24'd0, swap8(8'hC3)});
    chk("R8 no strobe without wr_n", {31'd0, per_wr_n}, 32'd1);

    // R10: write followed directly by read
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 16'h1234);
    chk("R5 even read", {24'd0, byte_out}, {24'd0, swap8(8'h12)});

    for (int i = 0; i < 600; i++) begin
      logic [3:0] r4;
      r4 = 4'($urandom);
      step(r4 == 4'd0, 1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), 16'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule